// File: doc/BRIEF.md
# Trace Capture Buffer with Saturating Valid Count

This block holds the most recent words captured by a debug unit during a trace run. After the host arms it, every accepted capture strobe writes one word into an eight-entry circular store. Once all eight entries are in use, the newest word replaces the oldest one. A status byte reports how many entries hold valid data. When the run is over, the host reads that byte and then pulls exactly that many words through a strobe-driven read port, oldest first.

The count goes up once for each accepted capture and stops at eight. Reading words out never lowers it. Its behaviour across a reset depends on the kind of reset, which arrives as a two-bit code together with a one-cycle reset request. A separate active-low power-on input clears everything at any time.

Top module: `dbg_trace_capture`

## Requirements
- R1: `status_o[7:4]` always reads 0. `status_o[3:0]` carries the valid count, where 0 through 8 mean that many valid words. Values above 8 never appear.
- R2: An `arm_i` pulse without `rst_req_i` clears the count to 0 and restarts the store at the next edge. A capture strobe in that same cycle is discarded.
- R3: A capture is accepted only when the block is armed, `enable_i`=1, `cap_stb_i`=1, and neither `arm_i` nor `rst_req_i` is high. Each accepted capture raises the count by one on the next edge. All other captures leave the count and the stored data unchanged.
- R4: The count stays at 8 once it gets there. Later accepted captures overwrite the oldest word, so the readable contents are always the last 8 accepted words.
- R5: `rd_data_o` shows the word at the read position. Each `rd_stb_i` that is not overridden by a capture, an arm or a reset advances the position by one. Once 8 words are held, the position wraps modulo 8. Reads never change the count.
- R6: `rst_n`=0, or `rst_req_i` with `rst_kind_i` = 00 (power-on) or 01 (other system reset), clears the count to 0.
- R7: `rst_req_i` with `rst_kind_i` = 11 (end-trace-to-reset) keeps the count and the stored words when `enable_i`=1 and `begin_i`=0. With any other `enable_i`/`begin_i` combination, it clears the count to 0.
- R8: `rst_req_i` with `rst_kind_i` = 10 (end-run) keeps the count and the stored words.
- R9: Every `rst_req_i` disarms the block, so captures are ignored until the next `arm_i`. A reset that keeps the count moves the read position back to the oldest word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| rst_req_i | input | 1 | One-cycle synchronous reset request |
| rst_kind_i | input | 2 | Reset kind: 00 power-on, 01 system, 10 end-run, 11 end-trace |
| arm_i | input | 1 | Arm pulse; clears count and store pointers |
| enable_i | input | 1 | Debug unit enable level |
| begin_i | input | 1 | Trace-begin mode level |
| cap_stb_i | input | 1 | Capture strobe |
| cap_data_i | input | DATA_W | Word to capture |
| rd_stb_i | input | 1 | Read strobe; advances the read position |
| rd_data_o | output | DATA_W | Word at the current read position |
| status_o | output | 8 | Status byte: zeros in 7:4, valid count in 3:0 |

## Verification
Two situations are the hardest to reach from the ports. The first is a reset that keeps the count while the buffer is full and the write pointer has already wrapped. Checking it needs more than eight captures, a partial readout, and then an end-run or end-trace reset with `enable_i`=1 and `begin_i`=0, after which the rewound read position must land on the true oldest word. The stimulus builds this sequence on purpose. It also adds a long pseudo-random stretch in which arm, capture, read and the four reset kinds collide in the same cycles, so that the priority rules get exercised.

// File: rtl/dtc_pkg.sv
package dtc_pkg;

  typedef enum logic [1:0] {
    RK_POWER     = 2'b00,
    RK_SYSTEM    = 2'b01,
    RK_END_RUN   = 2'b10,
    RK_END_TRACE = 2'b11
  } rst_kind_e;

  // Count after one more capture, held at the limit.
  function automatic int unsigned sat_inc(int unsigned cnt, int unsigned limit);
    return (cnt >= limit) ? limit : cnt + 1;
  endfunction

  // Pointer step with wrap for any depth.
  function automatic int unsigned ptr_step(int unsigned p, int unsigned depth);
    return (p + 1 >= depth) ? 0 : p + 1;
  endfunction

  // Location of the oldest valid word given next write slot and count.
  function automatic int unsigned oldest_slot(int unsigned wr, int unsigned cnt,
                                              int unsigned depth);
    return (wr + depth - cnt) % depth;
  endfunction

  // Does this reset kind preserve the trace state?
  function automatic logic keeps_state(rst_kind_e kind, logic en, logic bgn);
    case (kind)
      RK_END_RUN:   return 1'b1;
      RK_END_TRACE: return en & ~bgn;
      default:      return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/dtc_ctrl.sv
module dtc_ctrl
  import dtc_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      rst_req,
  input  rst_kind_e rst_kind,
  input  logic      arm,
  input  logic      enable,
  input  logic      bgn,
  input  logic      cap_stb,
  input  logic      rd_stb,
  output logic      wipe,
  output logic      rewind,
  output logic      cap_acc,
  output logic      rd_acc,
  output logic      armed
);

  logic armed_q;
  logic keep;
  logic arm_evt;

  assign keep    = keeps_state(rst_kind, enable, bgn);
  assign arm_evt = arm & ~rst_req;
  assign wipe    = (rst_req & ~keep) | arm_evt;
  assign rewind  = rst_req & keep;
  assign cap_acc = cap_stb & enable & armed_q & ~arm & ~rst_req;
  assign rd_acc  = rd_stb & ~cap_acc & ~arm & ~rst_req;
  assign armed   = armed_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       armed_q <= 1'b0;
    else if (rst_req) armed_q <= 1'b0;
    else if (arm)     armed_q <= 1'b1;
  end

endmodule

// File: rtl/dtc_count.sv
module dtc_count
  import dtc_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wipe,
  input  logic             cap_acc,
  output logic [CNT_W-1:0] cnt
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_inc;

  assign cnt_inc = CNT_W'(sat_inc(int'(cnt_q), DEPTH));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt_q <= '0;
    else if (wipe)    cnt_q <= '0;
    else if (cap_acc) cnt_q <= cnt_inc;
  end

  assign cnt = cnt_q;

endmodule

// File: rtl/dtc_ptrs.sv
module dtc_ptrs
  import dtc_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wipe,
  input  logic             rewind,
  input  logic             cap_acc,
  input  logic             rd_acc,
  input  logic [CNT_W-1:0] cnt,
  output logic [PTR_W-1:0] wr_ptr,
  output logic [PTR_W-1:0] rd_ptr
);

  logic [PTR_W-1:0] wr_q, rd_q;
  logic [PTR_W-1:0] wr_nxt;
  logic [CNT_W-1:0] cnt_nxt;
  logic [PTR_W-1:0] start_now, start_after_cap;

  assign wr_nxt          = PTR_W'(ptr_step(int'(wr_q), DEPTH));
  assign cnt_nxt         = CNT_W'(sat_inc(int'(cnt), DEPTH));
  assign start_now       = PTR_W'(oldest_slot(int'(wr_q), int'(cnt), DEPTH));
  assign start_after_cap = PTR_W'(oldest_slot(int'(wr_nxt), int'(cnt_nxt), DEPTH));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       wr_q <= '0;
    else if (wipe)    wr_q <= '0;
    else if (cap_acc) wr_q <= wr_nxt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       rd_q <= '0;
    else if (wipe)    rd_q <= '0;
    else if (rewind)  rd_q <= start_now;
    else if (cap_acc) rd_q <= start_after_cap;
    else if (rd_acc)  rd_q <= PTR_W'(ptr_step(int'(rd_q), DEPTH));
  end

  assign wr_ptr = wr_q;
  assign rd_ptr = rd_q;

endmodule

// File: rtl/dtc_store.sv
module dtc_store #(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 8,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [PTR_W-1:0]  waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [PTR_W-1:0]  raddr,
  output logic [DATA_W-1:0] rdata
);

  logic [DATA_W-1:0] slot [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    always_ff @(posedge clk) begin
      if (we && (waddr == PTR_W'(i))) slot[i] <= wdata;
    end
  end

  assign rdata = slot[raddr];

endmodule

// File: rtl/dbg_trace_capture.sv
module dbg_trace_capture
  import dtc_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 8,
  parameter int STAT_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rst_req_i,
  input  logic [1:0]        rst_kind_i,
  input  logic              arm_i,
  input  logic              enable_i,
  input  logic              begin_i,
  input  logic              cap_stb_i,
  input  logic [DATA_W-1:0] cap_data_i,
  input  logic              rd_stb_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic [STAT_W-1:0] status_o
);

  localparam int PTR_W = $clog2(DEPTH);
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic             wipe, rewind, cap_acc, rd_acc, armed;
  logic [CNT_W-1:0] cnt;
  logic [PTR_W-1:0] wr_ptr, rd_ptr;

  dtc_ctrl u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .rst_req  (rst_req_i),
    .rst_kind (rst_kind_e'(rst_kind_i)),
    .arm      (arm_i),
    .enable   (enable_i),
    .bgn      (begin_i),
    .cap_stb  (cap_stb_i),
    .rd_stb   (rd_stb_i),
    .wipe     (wipe),
    .rewind   (rewind),
    .cap_acc  (cap_acc),
    .rd_acc   (rd_acc),
    .armed    (armed)
  );

  dtc_count #(.DEPTH(DEPTH)) u_count (
    .clk     (clk),
    .rst_n   (rst_n),
    .wipe    (wipe),
    .cap_acc (cap_acc),
    .cnt     (cnt)
  );

  dtc_ptrs #(.DEPTH(DEPTH)) u_ptrs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wipe    (wipe),
    .rewind  (rewind),
    .cap_acc (cap_acc),
    .rd_acc  (rd_acc),
    .cnt     (cnt),
    .wr_ptr  (wr_ptr),
    .rd_ptr  (rd_ptr)
  );

  dtc_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
    .clk   (clk),
    .we    (cap_acc),
    .waddr (wr_ptr),
    .wdata (cap_data_i),
    .raddr (rd_ptr),
    .rdata (rd_data_o)
  );

  // Reserved upper bits tie to zero (R1).
  assign status_o = STAT_W'(cnt);

endmodule

// File: rtl/dtc_checker.sv
module dtc_checker #(
  parameter int DEPTH  = 8,
  parameter int STAT_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rst_req_i,
  input logic [1:0]        rst_kind_i,
  input logic              arm_i,
  input logic              enable_i,
  input logic              begin_i,
  input logic              rd_stb_i,
  input logic              cap_acc,
  input logic              armed,
  input logic [STAT_W-1:0] status_o
);

  logic [3:0] c;
  assign c = status_o[3:0];

  a_r1_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    status_o[STAT_W-1:4] == '0);

  a_r1_count_range: assert property (@(posedge clk) disable iff (!rst_n)
    int'(c) <= DEPTH);

  a_r2_arm_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (arm_i && !rst_req_i) |=> (c == 4'd0));

  a_r3_inc: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_acc && int'(c) < DEPTH) |=> (c == $past(c) + 4'd1));

  a_r3_needs_armed: assert property (@(posedge clk) disable iff (!rst_n)
    cap_acc |-> (armed && enable_i));

  a_r4_saturate: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_acc && int'(c) == DEPTH) |=> (int'(c) == DEPTH));

  a_r5_read_keeps_count: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb_i && !cap_acc && !arm_i && !rst_req_i) |=> $stable(c));

  a_r6_clear_reset: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_req_i && !rst_kind_i[1]) |=> (c == 4'd0));

  a_r7_trace_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_req_i && rst_kind_i == 2'b11 && enable_i && !begin_i) |=> $stable(c));

  a_r7_trace_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_req_i && rst_kind_i == 2'b11 && !(enable_i && !begin_i)) |=> (c == 4'd0));

  a_r8_endrun_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_req_i && rst_kind_i == 2'b10) |=> $stable(c));

  a_r9_disarm: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req_i |=> !armed);

endmodule

bind dbg_trace_capture dtc_checker #(.DEPTH(DEPTH), .STAT_W(STAT_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .rst_req_i  (rst_req_i),
  .rst_kind_i (rst_kind_i),
  .arm_i      (arm_i),
  .enable_i   (enable_i),
  .begin_i    (begin_i),
  .rd_stb_i   (rd_stb_i),
  .cap_acc    (cap_acc),
  .armed      (armed),
  .status_o   (status_o)
);

// File: tb/dbg_trace_capture_tb_top.sv
`timescale 1ns/1ps
module dbg_trace_capture_tb_top;

  localparam int DW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          rst_req = 1'b0;
  logic [1:0]    rst_kind = 2'b00;
  logic          arm = 1'b0, en = 1'b0, bgn = 1'b0;
  logic          cap = 1'b0, rd = 1'b0;
  logic [DW-1:0] cdata = '0;
  logic [DW-1:0] rd_data;
  logic [7:0]    status;

  int checks = 0, errors = 0;
  bit done = 0;
  string req = "R6";

  // reference model state
  logic [DW-1:0] q[$];
  int   k = 0;
  bit   armed_m = 0;

  always #4 clk = ~clk;

  dbg_trace_capture dut_i (
    .clk(clk), .rst_n(rst_n), .rst_req_i(rst_req), .rst_kind_i(rst_kind),
    .arm_i(arm), .enable_i(en), .begin_i(bgn), .cap_stb_i(cap),
    .cap_data_i(cdata), .rd_stb_i(rd), .rd_data_o(rd_data), .status_o(status)
  );

  task automatic chk(string r, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", r, act, exp, $time);
    end
  endtask

  // Behavioural update with the inputs present at this edge.
  task automatic model_edge();
    bit keep;
    if (rst_req) begin
      keep = (rst_kind == 2'b10) || (rst_kind == 2'b11 && en && !bgn);
      armed_m = 0;
      if (!keep) q.delete();
      k = 0;
    end else if (arm) begin
      armed_m = 1;
      q.delete();
      k = 0;
    end else if (cap && en && armed_m) begin
      q.push_back(cdata);
      if (q.size() > 8) void'(q.pop_front());
      k = 0;
    end else if (rd) begin
      k = (q.size() == 8) ? (k + 1) % 8 : k + 1;
    end
  endtask

  task automatic compare();
    chk("R1", {24'd0, status[7:4]}, 32'd0);
    chk(req, {28'd0, status[3:0]}, q.size());
    if (k < q.size()) chk(req, {16'd0, rd_data}, {16'd0, q[k]});
  endtask

  task automatic tick();
    @(posedge clk);
    model_edge();
    #2;
    compare();
    @(negedge clk);
    arm = 0; cap = 0; rd = 0; rst_req = 0;
  endtask

  task automatic capture_n(int n, logic [DW-1:0] base);
    for (int i = 0; i < n; i++) begin
      cap = 1; cdata = base + DW'(i); tick();
    end
  endtask

  task automatic read_n(int n);
    for (int i = 0; i < n; i++) begin rd = 1; tick(); end
  endtask

  task automatic do_reset(logic [1:0] kind);
    rst_req = 1; rst_kind = kind; tick();
  endtask

  initial begin : wd
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : stim
    logic [15:0] lf;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    req = "R6"; tick();                      // reset state: count 0
    // R3: no capture while unarmed
    en = 1; req = "R3"; capture_n(2, 16'h0100);
    // R2: arm with capture in the same cycle
    req = "R2"; arm = 1; cap = 1; cdata = 16'hDEAD; tick();
    req = "R3"; capture_n(3, 16'h1000);
    en = 0; capture_n(2, 16'h1100);          // R3: disabled, ignored
    en = 1;
    req = "R5"; read_n(2);                   // R5: oldest first, count kept
    // R4: saturate and overwrite, wrap on readout
    req = "R4"; capture_n(9, 16'h2000);
    req = "R5"; read_n(11);
    // R8: end-run keeps state, read position rewinds
    req = "R8"; do_reset(2'b10);
    req = "R5"; read_n(3);
    req = "R9"; capture_n(2, 16'h3000);      // disarmed: ignored
    // R7: end-trace hold when enabled and not begin
    req = "R2"; arm = 1; tick();
    req = "R3"; capture_n(5, 16'h4000);
    req = "R7"; bgn = 0; en = 1; do_reset(2'b11);
    read_n(5);
    bgn = 1; do_reset(2'b11);                // clears
    // R6: system and power-on kinds clear
    bgn = 0; arm = 1; tick();
    req = "R6"; capture_n(4, 16'h5000); do_reset(2'b01);
    arm = 1; tick(); capture_n(3, 16'h5100); do_reset(2'b00);
    arm = 1; tick(); capture_n(3, 16'h5200);
    en = 0; do_reset(2'b11);                 // R7: en=0 clears
    // mixed pseudo-random traffic
    req = "R5";
    lf = 16'hACE1;
    for (int i = 0; i < 600; i++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      en      = (lf[2:0] != 3'd0);
      bgn     = lf[3] & lf[9];
      arm     = (lf[7:4] == 4'd0);
      cap     = lf[8];
      cdata   = lf ^ 16'h5A5A;
      rd      = lf[11];
      rst_req = (lf[15:12] == 4'hF);
      rst_kind = lf[1:0];
      tick();
    end
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule